// File: doc/BRIEF.md
# Ratiometric PWM current decoder

This block sits on the controller side of a shunt current sensor. The sensor reports each measurement as the duty cycle of an active-low PWM line, and a SYNC line marks the measurement cycles. The decoder samples both lines on its own system clock and treats every SYNC level change as a cycle boundary. It counts how many clocks each cycle lasts and how many of them the PWM line spends high, which is the sensor's off state. From these counts it computes a signed current value in microvolts of shunt input.

Cycles taken while SYNC is high and cycles taken while SYNC is low carry different residual offsets. For that reason they are decoded as two separate channels, and each channel has its own offset correction. An optional averaging mode combines each result with the one before it, which cancels odd harmonics of centre-aligned PWM. The block produces one strobed sample per SYNC half-period.

Top module: `pwm_current_decoder`

## Requirements
- R1: Both inputs pass through a two-stage synchronizer. Only a level change of SYNC, rising or falling, ends a cycle. PWM activity while SYNC is steady produces no sample.
- R2: The partial cycle that runs when reset is released produces no sample, and neither does the first full cycle that follows it. The sample for full cycle n is formed only after cycle n+1 has ended.
- R3: For a cycle n of length L clocks, where the following cycle n+1 held the PWM line high for H clocks, the uncorrected value is 500000 − floor(2500000·H / L) µV. A duty of 20% therefore decodes to 0, and a higher duty decodes to a lower value.
- R4: If 10·H < L, the value is clamped to +250000 and the saturation flag is set. If 10·H > 3·L, the value is clamped to −250000 and the flag is set. The exact 10% and 30% points are not saturated.
- R5: sample_hi_phase is 1 when cycle n was a SYNC-high cycle. The offset ofs_hi is subtracted from such samples and ofs_lo from all others. The offset is applied after clamping.
- R6: With avg_en at 1, the output is floor((c + p)/2), where c is the current offset-corrected value and p is the previous one, whichever channel it came from. The saturation flag is the OR of the two flags. The first value after reset produces no strobe. With avg_en at 0, every value is strobed as it is.
- R7: sample_valid is a single-clock pulse. sample holds its value between strobes. For cycles of at least 32 clocks, every sample is strobed before the next cycle boundary.
- R8: During reset, sample_valid, sample_sat and sample are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | SYNC line; each level is one measurement cycle |
| pwm_in | input | 1 | Active-low duty-encoded measurement line |
| avg_en | input | 1 | 1 = average consecutive samples |
| ofs_hi | input | OFS_W | Signed offset for SYNC-high samples |
| ofs_lo | input | OFS_W | Signed offset for SYNC-low samples |
| sample | output | OUT_W | Signed decoded value in µV |
| sample_valid | output | 1 | One-clock strobe for sample |
| sample_hi_phase | output | 1 | Sample belongs to a SYNC-high cycle |
| sample_sat | output | 1 | Duty was outside the 10–30% band |

## Verification
The bench makes consecutive cycles differ in length, so a design that divided a cycle's off time by that same cycle's length, rather than by the previous cycle's, returns wrong values. It drives the exact 10% and 30% points and one clock beyond each, which catches a clamp comparison that uses the wrong inequality in either direction. It alternates channels under unequal offsets, so swapped offsets or channel tags show at once. It also drives negative averages with odd sums, which exposes rounding toward zero where the design should take the floor. A design that emitted output for the partial first cycle, or that counted PWM edges as cycle boundaries, would strobe where the bench's model expects nothing.

// File: rtl/pwmdec_pkg.sv
package pwmdec_pkg;
    // Number of quotient bits produced by the serial divider
    localparam int unsigned QBITS      = 20;
    // 2.5e6 µV per unit of duty: (0.2 - D) / 0.4 V expressed in µV
    localparam int          DUTY_SCALE = 2500000;
    localparam int          MID_UV     = 500000;
    localparam int          FULL_UV    = 250000;

    typedef enum logic [1:0] {
        RNG_IN   = 2'd0,
        RNG_HIGH = 2'd1,
        RNG_LOW  = 2'd2
    } range_e;
endpackage

// File: rtl/pwmdec_sync.sv
module pwmdec_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/pwmdec_meter.sv
module pwmdec_meter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_s,
    input  logic             pwm_s,
    output logic             meas_start,
    output logic [CNT_W-1:0] meas_off,
    output logic [CNT_W-1:0] meas_len,
    output logic             meas_hi
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             prev;
        logic [1:0]       edges;
        logic [CNT_W-1:0] len_cnt;
        logic [CNT_W-1:0] off_cnt;
        logic [CNT_W-1:0] len_hold;
        logic             hi_hold;
        logic             start;
        logic [CNT_W-1:0] m_off;
        logic [CNT_W-1:0] m_len;
        logic             m_hi;
    } meter_t;

    meter_t st_d, st_q;
    logic   bound;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.prev  = sync_s;
        bound      = sync_s ^ st_q.prev;
        if (bound) begin
            // this clock opens a new cycle
            st_d.len_cnt  = CNT_W'(1);
            st_d.off_cnt  = CNT_W'(pwm_s);
            st_d.len_hold = st_q.len_cnt;
            st_d.hi_hold  = st_q.prev;
            if (st_q.edges == 2'd2) begin
                st_d.start = 1'b1;
                st_d.m_off = st_q.off_cnt;
                st_d.m_len = st_q.len_hold;
                st_d.m_hi  = st_q.hi_hold;
            end else begin
                st_d.edges = st_q.edges + 2'd1;
            end
        end else begin
            if (st_q.len_cnt != CNT_MAX) st_d.len_cnt = st_q.len_cnt + CNT_W'(1);
            if (pwm_s && (st_q.off_cnt != CNT_MAX)) st_d.off_cnt = st_q.off_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign meas_start = st_q.start;
    assign meas_off   = st_q.m_off;
    assign meas_len   = st_q.m_len;
    assign meas_hi    = st_q.m_hi;
endmodule

// File: rtl/pwmdec_div.sv
module pwmdec_div #(
    parameter int NUM_W = 34,
    parameter int DEN_W = 12,
    parameter int QB    = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [QB-1:0]    quo
);
    localparam int IDX_W = $clog2(QB);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [IDX_W-1:0] idx;
        logic [NUM_W-1:0] rem;
        logic [DEN_W-1:0] den;
        logic [QB-1:0]    quo;
    } div_t;

    div_t             st_d, st_q;
    logic [NUM_W-1:0] trial;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        trial     = NUM_W'(st_q.den) << st_q.idx;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.rem  = num;
            st_d.den  = den;
            st_d.quo  = '0;
            st_d.idx  = IDX_W'(QB - 1);
        end else if (st_q.busy) begin
            if (st_q.rem >= trial) begin
                st_d.rem          = st_q.rem - trial;
                st_d.quo[st_q.idx] = 1'b1;
            end
            if (st_q.idx == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx - IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
    assign quo  = st_q.quo;
endmodule

// File: rtl/pwmdec_post.sv
module pwmdec_post
    import pwmdec_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int OFS_W = 16,
    parameter int OUT_W = 20,
    parameter int QB    = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_done,
    input  logic [QB-1:0]    quo,
    input  logic [CNT_W-1:0] m_off,
    input  logic [CNT_W-1:0] m_len,
    input  logic             m_hi,
    input  logic             avg_en,
    input  logic [OFS_W-1:0] ofs_hi,
    input  logic [OFS_W-1:0] ofs_lo,
    output logic [OUT_W-1:0] sample,
    output logic             sample_valid,
    output logic             sample_hi_phase,
    output logic             sample_sat
);
    localparam int CW = QB + 2;
    localparam int MW = CNT_W + 4;

    typedef struct packed {
        logic             valid;
        logic             hi;
        logic             sat;
        logic [OUT_W-1:0] sample;
        logic [CW-1:0]    prev;
        logic             prev_sat;
        logic             prev_vld;
    } post_t;

    post_t            st_d, st_q;
    range_e           cls;
    logic [MW-1:0]    off10, len1, len3;
    logic signed [CW-1:0] cur, cur_ofs, ofs_sel;
    logic signed [CW:0]   pair_sum, pair_avg;
    logic             cur_sat;

    always_comb begin
        off10 = MW'(m_off) * MW'(10);
        len1  = MW'(m_len);
        len3  = MW'(m_len) * MW'(3);
        if (off10 < len1)      cls = RNG_HIGH;
        else if (off10 > len3) cls = RNG_LOW;
        else                   cls = RNG_IN;

        case (cls)
            RNG_HIGH: cur = CW'(FULL_UV);
            RNG_LOW:  cur = -CW'(FULL_UV);
            default:  cur = CW'(MID_UV) - $signed({2'b00, quo});
        endcase
        cur_sat  = (cls != RNG_IN);
        ofs_sel  = m_hi ? CW'($signed(ofs_hi)) : CW'($signed(ofs_lo));
        cur_ofs  = cur - ofs_sel;
        pair_sum = (CW+1)'(cur_ofs) + (CW+1)'($signed(st_q.prev));
        pair_avg = pair_sum >>> 1;

        st_d       = st_q;
        st_d.valid = 1'b0;
        if (div_done) begin
            if (avg_en) begin
                if (st_q.prev_vld) begin
                    st_d.valid  = 1'b1;
                    st_d.sample = pair_avg[OUT_W-1:0];
                    st_d.sat    = cur_sat | st_q.prev_sat;
                    st_d.hi     = m_hi;
                end
            end else begin
                st_d.valid  = 1'b1;
                st_d.sample = cur_ofs[OUT_W-1:0];
                st_d.sat    = cur_sat;
                st_d.hi     = m_hi;
            end
            st_d.prev     = cur_ofs;
            st_d.prev_sat = cur_sat;
            st_d.prev_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample          = st_q.sample;
    assign sample_valid    = st_q.valid;
    assign sample_hi_phase = st_q.hi;
    assign sample_sat      = st_q.sat;
endmodule

// File: rtl/pwm_current_decoder.sv
module pwm_current_decoder
    import pwmdec_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int OFS_W = 16,
    parameter int OUT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic             pwm_in,
    input  logic             avg_en,
    input  logic [OFS_W-1:0] ofs_hi,
    input  logic [OFS_W-1:0] ofs_lo,
    output logic [OUT_W-1:0] sample,
    output logic             sample_valid,
    output logic             sample_hi_phase,
    output logic             sample_sat
);
    localparam int NUM_W = CNT_W + 22;

    logic [1:0]       line_s;
    logic             meas_start, meas_hi;
    logic [CNT_W-1:0] meas_off, meas_len;
    logic [NUM_W-1:0] div_num;
    logic             div_busy, div_done;
    logic [QBITS-1:0] div_quo;

    pwmdec_sync #(.W(2)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({sync_in, pwm_in}),
        .q   (line_s)
    );

    pwmdec_meter #(.CNT_W(CNT_W)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_s     (line_s[1]),
        .pwm_s      (line_s[0]),
        .meas_start (meas_start),
        .meas_off   (meas_off),
        .meas_len   (meas_len),
        .meas_hi    (meas_hi)
    );

    assign div_num = NUM_W'(meas_off) * NUM_W'(DUTY_SCALE);

    pwmdec_div #(.NUM_W(NUM_W), .DEN_W(CNT_W), .QB(QBITS)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (meas_start),
        .num   (div_num),
        .den   (meas_len),
        .busy  (div_busy),
        .done  (div_done),
        .quo   (div_quo)
    );

    pwmdec_post #(.CNT_W(CNT_W), .OFS_W(OFS_W), .OUT_W(OUT_W), .QB(QBITS)) u_post (
        .clk             (clk),
        .rst_n           (rst_n),
        .div_done        (div_done),
        .quo             (div_quo),
        .m_off           (meas_off),
        .m_len           (meas_len),
        .m_hi            (meas_hi),
        .avg_en          (avg_en),
        .ofs_hi          (ofs_hi),
        .ofs_lo          (ofs_lo),
        .sample          (sample),
        .sample_valid    (sample_valid),
        .sample_hi_phase (sample_hi_phase),
        .sample_sat      (sample_sat)
    );
endmodule

// File: rtl/pwmdec_checker.sv
module pwmdec_checker #(
    parameter int OUT_W = 20,
    parameter int OFS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_valid,
    input logic             sample_sat,
    input logic             sample_hi_phase,
    input logic             avg_en,
    input logic [OUT_W-1:0] sample,
    input logic [OFS_W-1:0] ofs_hi,
    input logic [OFS_W-1:0] ofs_lo,
    input logic             meas_start,
    input logic             div_busy
);
    localparam longint FULL = 250000;

    longint restored;
    always_comb begin
        restored = longint'($signed(sample))
                 + longint'($signed(sample_hi_phase ? ofs_hi : ofs_lo));
    end

    // R4: an unaveraged sample never exceeds the full-scale band once its offset is put back
    p_clamp_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !avg_en) |-> (restored >= -FULL && restored <= FULL));

    // R4: a saturated unaveraged sample sits exactly on one band edge
    p_sat_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && sample_sat && !avg_en) |-> (restored == FULL || restored == -FULL));

    // R7: the strobe lasts one clock
    p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R7: the value does not move without a strobe
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(sample));

    // R7: a new measurement never arrives while the previous division is still running
    p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start |-> !div_busy);
endmodule

bind pwm_current_decoder pwmdec_checker #(.OUT_W(OUT_W), .OFS_W(OFS_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sample_valid    (sample_valid),
    .sample_sat      (sample_sat),
    .sample_hi_phase (sample_hi_phase),
    .avg_en          (avg_en),
    .sample          (sample),
    .ofs_hi          (ofs_hi),
    .ofs_lo          (ofs_lo),
    .meas_start      (meas_start),
    .div_busy        (div_busy)
);

// File: tb/pwm_current_decoder_test.sv
module pwm_current_decoder_test;
    localparam int CNT_W = 12;
    localparam int OFS_W = 16;
    localparam int OUT_W = 20;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n, sync_in, pwm_in, avg_en;
    logic [OFS_W-1:0] ofs_hi, ofs_lo;
    logic [OUT_W-1:0] sample;
    logic             sample_valid, sample_hi_phase, sample_sat;

    pwm_current_decoder #(.CNT_W(CNT_W), .OFS_W(OFS_W), .OUT_W(OUT_W)) uut (
        .clk (clk), .rst_n (rst_n), .sync_in (sync_in), .pwm_in (pwm_in),
        .avg_en (avg_en), .ofs_hi (ofs_hi), .ofs_lo (ofs_lo),
        .sample (sample), .sample_valid (sample_valid),
        .sample_hi_phase (sample_hi_phase), .sample_sat (sample_sat)
    );

    typedef struct {
        longint v;
        bit     sat;
        bit     hi;
        string  req;
    } exp_t;

    exp_t   expq[$];
    int     total = 0, bad = 0;
    int     strobes = 0, pushes = 0;
    // model state
    bit     in_full;
    int     fin, cur_L, cur_H, last_L;
    bit     cur_lvl, last_lvl;
    longint prev_v;
    bit     prev_sat, prev_vld;
    string  tag;
    bit     finished = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint decode(int h, int l, output bit s);
        if (10 * h < l) begin s = 1; return 250000; end
        if (10 * h > 3 * l) begin s = 1; return -250000; end
        s = 0;
        return 64'sd500000 - (64'sd2500000 * h) / l;
    endfunction

    task automatic model_reset();
        in_full = 0; fin = 0; prev_vld = 0; prev_sat = 0; prev_v = 0;
        strobes = 0; pushes = 0;
    endtask

    // a SYNC level change finishes the cycle in progress
    task automatic boundary();
        exp_t e;
        bit s;
        longint v, c;
        if (in_full) begin
            fin++;
            if (fin >= 2) begin
                v = decode(cur_H, last_L, s);
                c = v - (last_lvl ? longint'($signed(ofs_hi)) : longint'($signed(ofs_lo)));
                e.hi = last_lvl;
                e.req = s ? "R4" : tag;
                if (avg_en) begin
                    if (prev_vld) begin
                        e.v = (c + prev_v) >>> 1;
                        e.sat = s | prev_sat;
                        e.req = tag;
                        expq.push_back(e);
                        pushes++;
                    end
                end else begin
                    e.v = c;
                    e.sat = s;
                    expq.push_back(e);
                    pushes++;
                end
                prev_v = c; prev_sat = s; prev_vld = 1;
            end
            last_L = cur_L;
            last_lvl = cur_lvl;
        end
    endtask

    task automatic run_cycle(int L, int H);
        @(negedge clk);
        boundary();
        sync_in = ~sync_in;
        in_full = 1; cur_L = L; cur_H = H; cur_lvl = sync_in;
        for (int i = 0; i < L; i++) begin
            if (i > 0) @(negedge clk);
            pwm_in = (i < H);
        end
    endtask

    task automatic finish_phase(string req);
        run_cycle(60, 0);
        check(expq.size() == 0, "R7", "samples still pending", expq.size(), 0);
        check(strobes == pushes, req, "strobe count", strobes, pushes);
    endtask

    task automatic do_reset(bit avg, int oh, int ol);
        @(negedge clk);
        rst_n = 0; sync_in = 0; pwm_in = 0;
        avg_en = avg; ofs_hi = OFS_W'(oh); ofs_lo = OFS_W'(ol);
        expq.delete();
        model_reset();
        repeat (3) @(negedge clk);
        check(sample_valid == 0, "R8", "valid in reset", sample_valid, 0);
        check(sample_sat == 0, "R8", "sat in reset", sample_sat, 0);
        check(sample == 0, "R8", "sample in reset", sample, 0);
        rst_n = 1;
        repeat (5) @(negedge clk);
    endtask

    // compare with the model on every clock
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished && sample_valid) begin
            strobes++;
            if (expq.size() == 0) begin
                check(0, "R2", "unexpected strobe", longint'($signed(sample)), 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(longint'($signed(sample)) == e.v, e.req, "value", longint'($signed(sample)), e.v);
                check(sample_sat == e.sat, e.req, "sat flag", sample_sat, e.sat);
                check(sample_hi_phase == e.hi, "R5", "channel", sample_hi_phase, e.hi);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        finished = 1;
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; sync_in = 0; pwm_in = 0; avg_en = 0; ofs_hi = '0; ofs_lo = '0;
        // phase A: transfer, clamps, cycle pairing (R3, R4, R2)
        tag = "R3";
        do_reset(0, 0, 0);
        run_cycle(200, 40);
        run_cycle(200, 40);
        check(strobes == 0, "R2", "strobe before second full cycle ended", strobes, 0);
        run_cycle(200, 40);
        run_cycle(200, 20);
        run_cycle(200, 60);
        run_cycle(200, 19);
        run_cycle(200, 61);
        run_cycle(150, 47);
        run_cycle(333, 50);
        run_cycle(97, 31);
        run_cycle(400, 0);
        run_cycle(120, 36);
        finish_phase("R3");

        // phase B: per-channel offsets (R5)
        tag = "R5";
        do_reset(0, 1234, -4321);
        run_cycle(250, 50);
        run_cycle(250, 30);
        run_cycle(180, 40);
        run_cycle(180, 50);
        run_cycle(300, 20);
        run_cycle(300, 95);
        run_cycle(250, 50);
        run_cycle(128, 40);
        finish_phase("R5");

        // phase C: averaging with odd and negative sums (R6)
        tag = "R6";
        do_reset(1, -77, 301);
        run_cycle(200, 40);
        run_cycle(200, 25);
        run_cycle(200, 55);
        run_cycle(210, 33);
        run_cycle(190, 15);
        run_cycle(200, 70);
        run_cycle(220, 41);
        run_cycle(200, 40);
        run_cycle(203, 59);
        finish_phase("R6");

        // phase D: PWM activity with SYNC steady gives nothing (R1)
        tag = "R1";
        do_reset(0, 0, 0);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); pwm_in = 1;
            repeat (4) @(negedge clk);
            pwm_in = 0;
            repeat (3) @(negedge clk);
        end
        check(strobes == 0, "R1", "strobe without SYNC change", strobes, 0);
        run_cycle(200, 30);
        run_cycle(200, 45);
        run_cycle(200, 45);
        finish_phase("R1");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule